// File: doc/BRIEF.md
# Clocked Pulse-Logic Gate Cells

This block models timed pulse logic inside an ordinary synchronous clock domain. A logic value is the presence or absence of a one-cycle strobe within an evaluation period. A shared period strobe, `tick`, closes one period and opens the next. Each cell is built around a destructive-readout storage element. The element is set by an arriving pulse and read and cleared by a clearing pulse. On a read it emits a single output strobe, but only if it held a pulse.

The top instantiates four kinds of lanes, each repeated a parameterized number of times:
- bare storage lanes with their own set and clear strobes;
- clocked OR lanes;
- clocked AND lanes;
- clocked NOT lanes.

The OR, AND and NOT lanes collect input pulses during a period. At `tick` they emit a strobe on the next cycle according to what they collected, and then start empty. All output strobes are registered and appear exactly one clock cycle after the strobe that caused them. Lanes share nothing except `tick`, the clock and the reset.

Top module: `flux_pulse_cells`

## Requirements
- R1: A storage lane that received a `reg_set` strobe emits exactly one `reg_out` strobe one cycle after its next `reg_clr` strobe (bit i of each vector belongs to lane i).
- R2: A `reg_set` strobe on a lane that already holds a pulse changes nothing, and a `reg_clr` strobe on an empty lane produces no `reg_out` strobe.
- R3: A read empties the storage lane, so a second `reg_clr` without a new `reg_set` produces no strobe, and every output strobe lasts one cycle.
- R4: When `reg_set` and `reg_clr` hit a storage lane in the same cycle, the read reports the state held before that cycle and the lane ends up holding a pulse.
- R5: An OR lane emits one `or_out` strobe one cycle after `tick` if any number of `or_a` or `or_b` strobes, one or more, arrived during the period, and emits nothing otherwise.
- R6: An AND lane emits an `and_out` strobe one cycle after `tick` only if both `and_a` and `and_b` strobed during the period, at the same or at different cycles.
- R7: A NOT lane emits a `not_out` strobe one cycle after `tick` only if no `not_in` strobe arrived during the period.
- R8: `tick` empties every gate lane, so pulses collected in one period have no effect on the outputs of the following period.
- R9: An input strobe in the same cycle as `tick` does not count toward the period that `tick` closes; it is counted in the period that follows.
- R10: While `rst` is high all stored pulses are cleared and no output strobe is emitted on the cycle after any reset cycle.
- R11: Lanes are independent: stimulus on one lane never changes another lane's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Period-boundary strobe shared by all gate lanes |
| reg_set | input | REG_LANES | Set strobes, storage lanes |
| reg_clr | input | REG_LANES | Read-and-clear strobes, storage lanes |
| reg_out | output | REG_LANES | Readout strobes, storage lanes |
| or_a | input | OR_LANES | First input strobes, OR lanes |
| or_b | input | OR_LANES | Second input strobes, OR lanes |
| or_out | output | OR_LANES | Output strobes, OR lanes |
| and_a | input | AND_LANES | First input strobes, AND lanes |
| and_b | input | AND_LANES | Second input strobes, AND lanes |
| and_out | output | AND_LANES | Output strobes, AND lanes |
| not_in | input | NOT_LANES | Input strobes, NOT lanes |
| not_out | output | NOT_LANES | Output strobes, NOT lanes |

## Verification
The bench builds the block with two lanes of each kind. With two lanes, every scenario can drive one lane and leave its neighbour idle or drive it differently, so cross-lane leakage (R11) shows up in every vector compared. Two lanes also let the same-cycle collision of R4 and R9 be run on a held lane and an empty lane side by side in one step.

// File: rtl/flux_cell_pkg.sv
`timescale 1ns/1ps
package flux_cell_pkg;

    typedef enum logic {
        CELL_EMPTY = 1'b0,
        CELL_HELD  = 1'b1
    } cell_state_e;

    // A clear acts on the old state; a simultaneous set lands afterwards.
    function automatic cell_state_e cell_next(input cell_state_e cur,
                                              input logic set_p,
                                              input logic clr_p);
        if (set_p)      return CELL_HELD;
        else if (clr_p) return CELL_EMPTY;
        else            return cur;
    endfunction

    function automatic logic cell_fires(input cell_state_e cur, input logic clr_p);
        return clr_p && (cur == CELL_HELD);
    endfunction

endpackage

// File: rtl/flux_dro_cell.sv
`timescale 1ns/1ps
module flux_dro_cell
    import flux_cell_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        set_p,
    input  logic        clr_p,
    output logic        rd_p,
    output cell_state_e state_o
);
    cell_state_e state_q;
    logic        rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= CELL_EMPTY;
            rd_q    <= 1'b0;
        end else begin
            state_q <= cell_next(state_q, set_p, clr_p);
            rd_q    <= cell_fires(state_q, clr_p);
        end
    end

    assign rd_p    = rd_q;
    assign state_o = state_q;

    assert_fire_needs_held_R1: assert property (@(posedge clk) disable iff (rst)
        rd_q |-> ($past(state_q) == CELL_HELD && $past(clr_p)));

    assert_set_keeps_held_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CELL_HELD && set_p && !clr_p) |=> (state_q == CELL_HELD && !rd_q));

    assert_empty_read_silent_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == CELL_EMPTY && clr_p) |=> !rd_q);

    assert_read_empties_R3: assert property (@(posedge clk) disable iff (rst)
        (clr_p && !set_p) |=> (state_q == CELL_EMPTY));

    assert_quiet_reset_R10: assert property (@(posedge clk)
        rst |=> (!rd_q && state_q == CELL_EMPTY));
endmodule

// File: rtl/flux_or_cell.sv
`timescale 1ns/1ps
module flux_or_cell
    import flux_cell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic in_a,
    input  logic in_b,
    output logic out_p
);
    cell_state_e st;

    // Both inputs merge onto a single storage element.
    flux_dro_cell u_store (
        .clk     (clk),
        .rst     (rst),
        .set_p   (in_a | in_b),
        .clr_p   (tick),
        .rd_p    (out_p),
        .state_o (st)
    );

    assert_or_one_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        out_p |-> ($past(tick) && $past(st) == CELL_HELD));

    assert_or_tick_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !in_a && !in_b) |=> (st == CELL_EMPTY));
endmodule

// File: rtl/flux_and_cell.sv
`timescale 1ns/1ps
module flux_and_cell
    import flux_cell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic in_a,
    input  logic in_b,
    output logic out_p
);
    cell_state_e st_a;
    cell_state_e st_b;
    logic        rd_a;
    logic        rd_b;

    // One storage element per input; both released together by tick.
    flux_dro_cell u_store_a (
        .clk (clk), .rst (rst), .set_p (in_a), .clr_p (tick),
        .rd_p (rd_a), .state_o (st_a)
    );
    flux_dro_cell u_store_b (
        .clk (clk), .rst (rst), .set_p (in_b), .clr_p (tick),
        .rd_p (rd_b), .state_o (st_b)
    );

    assign out_p = rd_a & rd_b;

    assert_and_needs_both_R6: assert property (@(posedge clk) disable iff (rst)
        out_p |-> ($past(tick) && $past(st_a) == CELL_HELD && $past(st_b) == CELL_HELD));

    assert_and_release_together_R6: assert property (@(posedge clk) disable iff (rst)
        (rd_a || rd_b) |-> $past(tick));
endmodule

// File: rtl/flux_not_cell.sv
`timescale 1ns/1ps
module flux_not_cell
    import flux_cell_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic in_p,
    output logic out_p
);
    cell_state_e st;
    logic        rd_unused;
    logic        inv_q;

    flux_dro_cell u_store (
        .clk     (clk),
        .rst     (rst),
        .set_p   (in_p),
        .clr_p   (tick),
        .rd_p    (rd_unused),
        .state_o (st)
    );

    // Emit on tick only when the period collected nothing.
    always_ff @(posedge clk) begin
        if (rst) inv_q <= 1'b0;
        else     inv_q <= tick && (st == CELL_EMPTY);
    end

    assign out_p = inv_q;

    assert_not_silent_after_input_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && st == CELL_HELD) |=> !out_p);

    assert_not_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(out_p && rd_unused));

    assert_not_quiet_reset_R10: assert property (@(posedge clk)
        rst |=> !out_p);
endmodule

// File: rtl/flux_pulse_cells.sv
`timescale 1ns/1ps
module flux_pulse_cells
    import flux_cell_pkg::*;
#(
    parameter int REG_LANES = 2,
    parameter int OR_LANES  = 2,
    parameter int AND_LANES = 2,
    parameter int NOT_LANES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic [REG_LANES-1:0] reg_set,
    input  logic [REG_LANES-1:0] reg_clr,
    output logic [REG_LANES-1:0] reg_out,
    input  logic [OR_LANES-1:0]  or_a,
    input  logic [OR_LANES-1:0]  or_b,
    output logic [OR_LANES-1:0]  or_out,
    input  logic [AND_LANES-1:0] and_a,
    input  logic [AND_LANES-1:0] and_b,
    output logic [AND_LANES-1:0] and_out,
    input  logic [NOT_LANES-1:0] not_in,
    output logic [NOT_LANES-1:0] not_out
);
    for (genvar i = 0; i < REG_LANES; i++) begin : g_reg
        cell_state_e st;
        flux_dro_cell u_cell (
            .clk (clk), .rst (rst), .set_p (reg_set[i]), .clr_p (reg_clr[i]),
            .rd_p (reg_out[i]), .state_o (st)
        );
        assert_collision_keeps_held_R4: assert property (@(posedge clk) disable iff (rst)
            (reg_set[i] && reg_clr[i] && st == CELL_HELD) |=> (reg_out[i] && st == CELL_HELD));
    end

    for (genvar i = 0; i < OR_LANES; i++) begin : g_or
        flux_or_cell u_or (
            .clk (clk), .rst (rst), .tick (tick),
            .in_a (or_a[i]), .in_b (or_b[i]), .out_p (or_out[i])
        );
    end

    for (genvar i = 0; i < AND_LANES; i++) begin : g_and
        flux_and_cell u_and (
            .clk (clk), .rst (rst), .tick (tick),
            .in_a (and_a[i]), .in_b (and_b[i]), .out_p (and_out[i])
        );
    end

    for (genvar i = 0; i < NOT_LANES; i++) begin : g_not
        flux_not_cell u_not (
            .clk (clk), .rst (rst), .tick (tick),
            .in_p (not_in[i]), .out_p (not_out[i])
        );
    end

    assert_gate_out_only_after_tick_R9: assert property (@(posedge clk) disable iff (rst)
        (|{or_out, and_out, not_out}) |-> $past(tick));
endmodule

// File: tb/flux_pulse_cells_tb.sv
`timescale 1ns/1ps
module flux_pulse_cells_tb_top;
    localparam int L = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic [L-1:0] reg_set = '0, reg_clr = '0, reg_out;
    logic [L-1:0] or_a = '0, or_b = '0, or_out;
    logic [L-1:0] and_a = '0, and_b = '0, and_out;
    logic [L-1:0] not_in = '0, not_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flux_pulse_cells #(.REG_LANES(L), .OR_LANES(L), .AND_LANES(L), .NOT_LANES(L)) dut_i (
        .clk (clk), .rst (rst), .tick (tick),
        .reg_set (reg_set), .reg_clr (reg_clr), .reg_out (reg_out),
        .or_a (or_a), .or_b (or_b), .or_out (or_out),
        .and_a (and_a), .and_b (and_b), .and_out (and_out),
        .not_in (not_in), .not_out (not_out)
    );

    // Inputs set at a falling edge are sampled at the next rising edge;
    // the registered response is visible at the falling edge after it.
    task automatic step();
        @(negedge clk);
        tick = 1'b0; reg_set = '0; reg_clr = '0;
        or_a = '0; or_b = '0; and_a = '0; and_b = '0; not_in = '0;
    endtask

    task automatic chk(input string req, input logic [L-1:0] act, input logic [L-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        tick = 1'b1; or_a = 2'b11; and_a = 2'b11; and_b = 2'b11;
        step();
        chk("R10 not quiet in reset", not_out, 2'b00);
        chk("R10 or quiet in reset", or_out, 2'b00);
        rst = 1'b0;
        step();
        chk("R10 reg idle after reset", reg_out, 2'b00);
        reg_set = 2'b01; step();
        rst = 1'b1; step();
        rst = 1'b0; reg_clr = 2'b01; step();
        chk("R10 reset clears storage", reg_out, 2'b00);
        tick = 1'b1; step();
        chk("R10 no and carry over reset", and_out, 2'b00);
    endtask

    task automatic t_storage();
        reg_set = 2'b01; step();
        chk("R1 no output on set", reg_out, 2'b00);
        step();
        reg_clr = 2'b11; step();
        chk("R1 readout after clear lane0 only (R11)", reg_out, 2'b01);
        step();
        chk("R3 pulse lasts one cycle", reg_out, 2'b00);
        reg_clr = 2'b01; step();
        chk("R3 second clear silent", reg_out, 2'b00);
        reg_set = 2'b10; step();
        reg_set = 2'b10; step();
        reg_clr = 2'b10; step();
        chk("R2 double set gives one readout", reg_out, 2'b10);
        reg_clr = 2'b10; step();
        chk("R2 clear on empty silent", reg_out, 2'b00);
    endtask

    task automatic t_collision();
        reg_set = 2'b10; step();
        reg_set = 2'b11; reg_clr = 2'b11; step();
        chk("R4 collision reports old state", reg_out, 2'b10);
        reg_clr = 2'b11; step();
        chk("R4 collision leaves lanes held", reg_out, 2'b11);
    endtask

    task automatic t_or();
        or_a = 2'b01; step();
        or_b = 2'b01; step();
        or_a = 2'b01; step();
        tick = 1'b1; step();
        chk("R5 or multiple pulses one output", or_out, 2'b01);
        or_b = 2'b10; step();
        tick = 1'b1; step();
        chk("R5 or single b pulse lane1", or_out, 2'b10);
        tick = 1'b1; step();
        chk("R5 or empty period silent", or_out, 2'b00);
    endtask

    task automatic t_and();
        and_a = 2'b11; step();
        step(); step();
        and_b = 2'b01; step();
        tick = 1'b1; step();
        chk("R6 and staggered pulses", and_out, 2'b01);
        and_b = 2'b10; step();
        tick = 1'b1; step();
        chk("R8 and held a not carried", and_out, 2'b00);
        and_a = 2'b10; and_b = 2'b10; step();
        tick = 1'b1; step();
        chk("R6 and same-cycle pulses lane1", and_out, 2'b10);
    endtask

    task automatic t_not();
        not_in = 2'b01; step();
        tick = 1'b1; step();
        chk("R7 not suppressed by input", not_out, 2'b10);
        tick = 1'b1; step();
        chk("R7 not fires on empty period", not_out, 2'b11);
    endtask

    task automatic t_period_clear();
        or_a = 2'b10; step();
        tick = 1'b1; step();
        chk("R8 or first period", or_out, 2'b10);
        tick = 1'b1; step();
        chk("R8 or cleared by tick", or_out, 2'b00);
    endtask

    task automatic t_same_cycle();
        tick = 1'b1; or_a = 2'b01; not_in = 2'b01; and_a = 2'b01; step();
        chk("R9 or input at tick not in closing period", or_out, 2'b00);
        chk("R9 not input at tick not in closing period", not_out, 2'b11);
        and_b = 2'b01; step();
        tick = 1'b1; step();
        chk("R9 or input counted next period", or_out, 2'b01);
        chk("R9 not input counted next period", not_out, 2'b10);
        chk("R9 and a at tick joins next period", and_out, 2'b01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_storage();
        t_collision();
        t_or();
        t_and();
        t_not();
        t_period_clear();
        t_same_cycle();
        repeat (2) step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule